// File: doc/BRIEF.md
# Processor Init Pulse Generator

This block produces an internal, active-low initialization signal for the processor cores. It is a virtual wire inside the chip and never reaches a device pin. Software starts the signal through two small control registers reached by a single-cycle register-write port. The first register holds a fast-init bit. The second holds a CPU-reset bit and a system-reset select bit.

A qualifying rising transition of a control bit pulls the init output low. The output then stays low for a fixed count of bus clocks and is released high. At the release, a one-cycle done strobe marks the end of the pulse. A trigger that arrives while a pulse is running is dropped. The running pulse is neither stretched nor restarted.

The registers can be read at any time through dedicated read ports. Integrators tie the init output into the cores' soft-init path.

Top module: `proc_init_pulse_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the fast-init bit, the CPU-reset bit and the system-reset select bit. From the first clock after reset, `init_n` reads 1 and `init_done` reads 0.
- R2: A write is a cycle with `wr_en`=1. With `sel_fast`=1, the write loads `wdata[0]` into the fast-init bit. With `sel_rstctl`=1, it loads `wdata[0]` into the CPU-reset bit and `wdata[1]` into the system-reset select bit. Both selects may be set together. `rd_fast` and `rd_rstctl` (bit 0 CPU-reset, bit 1 system-reset select) show the stored values from the cycle after the write.
- R3: A write that takes the fast-init bit from 0 to 1 drives `init_n` low, starting in the cycle after the write.
- R4: A write that takes the CPU-reset bit from 0 to 1, while the same write sets the system-reset select bit to 0, drives `init_n` low, starting in the cycle after the write.
- R5: A write that takes the CPU-reset bit from 0 to 1 while the same write sets the system-reset select bit to 1 leaves `init_n` high.
- R6: Writing 1 to a bit already at 1, writing 0 to a bit, or raising `sel_fast`/`sel_rstctl` with `wr_en`=0 leaves `init_n` high.
- R7: Once started, `init_n` stays low for exactly PULSE_LEN (default 16) consecutive cycles and then returns high.
- R8: A cause event during a running pulse is ignored. The pulse ends at its original time, and no second pulse follows from that event.
- R9: `init_done` is high for exactly one cycle, the first cycle in which `init_n` is high again after a pulse, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| sel_fast | input | 1 | Selects the fast-init register for the write |
| sel_rstctl | input | 1 | Selects the reset-control register for the write |
| wdata | input | 2 | Write data |
| rd_fast | output | 1 | Current fast-init bit |
| rd_rstctl | output | 2 | Current reset-control bits: bit 0 CPU-reset, bit 1 system-reset select |
| init_n | output | 1 | Active-low processor init pulse |
| init_done | output | 1 | One-cycle strobe at the end of each pulse |

## Verification
A wrong stored bit appears on `rd_fast` or `rd_rstctl` one cycle after the write. A wrong stored bit can also turn the next write into a missed or spurious pulse, so `init_n` is wrong one cycle after that write. A miscounting pulse timer shows as a low width other than 16 cycles, or as an `init_done` strobe that comes early, comes late or repeats. A timer that wrongly accepts triggers while busy shows as a stretched low phase, or as a second pulse right after the first. Both appear within 17 cycles of the trigger.

// File: rtl/init_pulse_pkg.sv
package init_pulse_pkg;

    localparam int unsigned DATA_W     = 2;
    localparam int unsigned CPU_BIT    = 0;
    localparam int unsigned SYSSEL_BIT = 1;

    typedef struct packed {
        logic sys_sel;
        logic cpu_rst;
    } rstctl_t;

    typedef struct packed {
        logic fast;
        logic cpu;
    } cause_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_LOW  = 1'b1
    } tmr_state_e;

    function automatic logic rising(input logic old_v, input logic new_v);
        return ~old_v & new_v;
    endfunction

    function automatic rstctl_t unpack_rstctl(input logic [DATA_W-1:0] d);
        rstctl_t r;
        r.cpu_rst = d[CPU_BIT];
        r.sys_sel = d[SYSSEL_BIT];
        return r;
    endfunction

endpackage

// File: rtl/init_ctrl_regs.sv
module init_ctrl_regs
    import init_pulse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              sel_fast,
    input  logic              sel_rstctl,
    input  logic [DATA_W-1:0] wdata,
    output logic              fast_q,
    output logic              fast_nxt,
    output rstctl_t           rc_q,
    output rstctl_t           rc_nxt
);

    always_comb begin
        fast_nxt = fast_q;
        rc_nxt   = rc_q;
        if (wr_en && sel_fast) begin
            fast_nxt = wdata[0];
        end
        if (wr_en && sel_rstctl) begin
            rc_nxt = unpack_rstctl(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_q <= 1'b0;
            rc_q   <= '0;
        end else begin
            fast_q <= fast_nxt;
            rc_q   <= rc_nxt;
        end
    end

    // R2: an unselected register keeps its value
    a_r2_fast_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel_fast) |=> $stable(fast_q));
    a_r2_rc_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel_rstctl) |=> $stable(rc_q));

endmodule

// File: rtl/init_cause_detect.sv
module init_cause_detect
    import init_pulse_pkg::*;
(
    input  logic    fast_q,
    input  logic    fast_nxt,
    input  rstctl_t rc_q,
    input  rstctl_t rc_nxt,
    output cause_t  cause,
    output logic    trigger
);

    always_comb begin
        cause.fast = rising(fast_q, fast_nxt);
        cause.cpu  = rising(rc_q.cpu_rst, rc_nxt.cpu_rst) & ~rc_nxt.sys_sel;
        trigger    = |cause;
    end

endmodule

// File: rtl/init_pulse_timer.sv
module init_pulse_timer
    import init_pulse_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic init_n,
    output logic init_done
);

    localparam int unsigned CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

    tmr_state_e       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TMR_IDLE;
            cnt       <= '0;
            init_done <= 1'b0;
        end else begin
            init_done <= 1'b0;
            unique case (state)
                TMR_IDLE: begin
                    if (trigger) begin
                        state <= TMR_LOW;
                        cnt   <= LAST;
                    end
                end
                TMR_LOW: begin
                    if (cnt == '0) begin
                        state     <= TMR_IDLE;
                        init_done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= TMR_IDLE;
            endcase
        end
    end

    assign init_n = (state == TMR_IDLE);

    // checker counter for the low width
    logic [CNT_W:0] low_run;
    always_ff @(posedge clk) begin
        if (rst) low_run <= '0;
        else if (!init_n) low_run <= low_run + 1'b1;
        else low_run <= '0;
    end

    a_r7_low_not_too_long: assert property (@(posedge clk) disable iff (rst)
        low_run <= (CNT_W+1)'(PULSE_LEN));
    a_r7_low_exact: assert property (@(posedge clk) disable iff (rst)
        $rose(init_n) |-> (low_run == (CNT_W+1)'(PULSE_LEN)));
    a_r8_count_advances: assert property (@(posedge clk) disable iff (rst)
        (!init_n && cnt != '0) |=> (!init_n && cnt == $past(cnt) - 1'b1));
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        init_done |=> !init_done);
    a_r9_done_at_release: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (init_n && $past(!init_n)));

endmodule

// File: rtl/proc_init_pulse_gen.sv
module proc_init_pulse_gen
    import init_pulse_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              sel_fast,
    input  logic              sel_rstctl,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_fast,
    output logic [DATA_W-1:0] rd_rstctl,
    output logic              init_n,
    output logic              init_done
);

    logic    fast_q, fast_nxt;
    rstctl_t rc_q, rc_nxt;
    cause_t  cause;
    logic    trigger;

    init_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .sel_fast   (sel_fast),
        .sel_rstctl (sel_rstctl),
        .wdata      (wdata),
        .fast_q     (fast_q),
        .fast_nxt   (fast_nxt),
        .rc_q       (rc_q),
        .rc_nxt     (rc_nxt)
    );

    init_cause_detect u_cause (
        .fast_q   (fast_q),
        .fast_nxt (fast_nxt),
        .rc_q     (rc_q),
        .rc_nxt   (rc_nxt),
        .cause    (cause),
        .trigger  (trigger)
    );

    init_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .trigger   (trigger),
        .init_n    (init_n),
        .init_done (init_done)
    );

    always_comb begin
        rd_fast               = fast_q;
        rd_rstctl             = '0;
        rd_rstctl[CPU_BIT]    = rc_q.cpu_rst;
        rd_rstctl[SYSSEL_BIT] = rc_q.sys_sel;
    end

    // R3: fast-init rise from idle starts the pulse
    a_r3_fast_starts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_fast && wdata[0] && !rd_fast && init_n) |=> !init_n);
    // R5: CPU-reset rise with system select set does not start a pulse
    a_r5_sysel_blocks: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_rstctl && !sel_fast && wdata[SYSSEL_BIT] && init_n) |=> init_n);
    // R6: no write, no pulse start
    a_r6_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && init_n) |=> init_n);
    // R1: after reset the output is released
    a_r1_reset_release: assert property (@(posedge clk)
        $past(rst) |-> (init_n && !init_done));

endmodule

// File: tb/sim_proc_init_pulse_gen.sv
module sim_proc_init_pulse_gen;

    localparam int LEN = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, sel_fast = 1'b0, sel_rstctl = 1'b0;
    logic [1:0] wdata = 2'b00;
    logic       rd_fast, init_n, init_done;
    logic [1:0] rd_rstctl;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    proc_init_pulse_gen #(.PULSE_LEN(LEN)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel_fast(sel_fast),
        .sel_rstctl(sel_rstctl), .wdata(wdata), .rd_fast(rd_fast),
        .rd_rstctl(rd_rstctl), .init_n(init_n), .init_done(init_done)
    );

    // behavioural reference model
    int m_fast = 0, m_cpu = 0, m_sys = 0, m_left = 0, m_done = 0;
    always @(posedge clk) begin
        int nf, nc, ns, trig;
        if (rst) begin
            m_fast = 0; m_cpu = 0; m_sys = 0; m_left = 0; m_done = 0;
        end else begin
            nf = m_fast; nc = m_cpu; ns = m_sys;
            if (wr_en && sel_fast) nf = int'(wdata[0]);
            if (wr_en && sel_rstctl) begin
                nc = int'(wdata[0]);
                ns = int'(wdata[1]);
            end
            trig = ((m_fast == 0 && nf == 1) || (m_cpu == 0 && nc == 1 && ns == 0)) ? 1 : 0;
            m_done = 0;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) m_done = 1;
            end else if (trig == 1) begin
                m_left = LEN;
            end
            m_fast = nf; m_cpu = nc; m_sys = ns;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(tag, "init_n", int'(init_n), (m_left == 0) ? 1 : 0);
            chk("R9", "init_done", int'(init_done), m_done);
            chk("R2", "rd_fast", int'(rd_fast), m_fast);
            chk("R2", "rd_rstctl", int'(rd_rstctl), m_sys * 2 + m_cpu);
        end
    end

    int low_cnt = 0, done_cnt = 0;
    always @(negedge clk) begin
        if (!init_n) low_cnt++;
        if (init_done) done_cnt++;
    end

    task automatic wr(input logic f, input logic r, input logic [1:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; sel_fast = f; sel_rstctl = r; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0; sel_fast = 1'b0; sel_rstctl = 1'b0; wdata = 2'b00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "init_n after reset", int'(init_n), 1);
        chk("R1", "init_done after reset", int'(init_done), 0);
        chk("R1", "regs after reset", int'({rd_rstctl, rd_fast}), 0);

        // R3 fast rise, R7 width, R9 done
        tag = "R3";
        low_cnt = 0; done_cnt = 0;
        wr(1'b1, 1'b0, 2'b01);
        chk("R3", "init_n low after fast write", int'(init_n), 0);
        tag = "R7";
        idle(LEN + 4);
        chk("R7", "low width", low_cnt, LEN);
        chk("R9", "done count", done_cnt, 1);

        // R6 repeat 1 and 0 writes, write-enable low
        tag = "R6";
        low_cnt = 0;
        wr(1'b1, 1'b0, 2'b01);
        wr(1'b1, 1'b0, 2'b00);
        @(negedge clk); #1;
        sel_fast = 1'b1; sel_rstctl = 1'b1; wdata = 2'b01;
        idle(2);
        sel_fast = 1'b0; sel_rstctl = 1'b0; wdata = 2'b00;
        idle(3);
        chk("R6", "no pulse from non-rising writes", low_cnt, 0);

        // R5 cpu rise with system select set
        tag = "R5";
        wr(1'b0, 1'b1, 2'b11);
        idle(3);
        chk("R5", "no pulse with sys select", low_cnt, 0);
        chk("R2", "rstctl readback", int'(rd_rstctl), 3);
        wr(1'b0, 1'b1, 2'b11);
        idle(2);
        chk("R6", "cpu already 1 no pulse", low_cnt, 0);

        // R4 cpu rise with select 0
        tag = "R4";
        wr(1'b0, 1'b1, 2'b00);
        idle(2);
        low_cnt = 0; done_cnt = 0;
        wr(1'b0, 1'b1, 2'b01);
        chk("R4", "init_n low after cpu write", int'(init_n), 0);
        tag = "R7";
        idle(LEN + 3);
        chk("R7", "low width cpu", low_cnt, LEN);
        chk("R9", "done count cpu", done_cnt, 1);

        // R8 causes during pulse ignored
        tag = "R8";
        wr(1'b1, 1'b1, 2'b00);
        idle(2);
        low_cnt = 0; done_cnt = 0;
        wr(1'b1, 1'b0, 2'b01);
        idle(5);
        wr(1'b0, 1'b1, 2'b01);
        idle(LEN + 6);
        chk("R8", "pulse not extended", low_cnt, LEN);
        chk("R8", "single done", done_cnt, 1);

        // both selects together, both rising
        tag = "R2";
        wr(1'b1, 1'b1, 2'b00);
        idle(2);
        low_cnt = 0;
        tag = "R3";
        wr(1'b1, 1'b1, 2'b01);
        idle(LEN + 4);
        chk("R7", "width with dual cause", low_cnt, LEN);

        // reset during pulse
        tag = "R1";
        wr(1'b1, 1'b0, 2'b00);
        wr(1'b1, 1'b0, 2'b01);
        idle(3);
        @(negedge clk); #1; rst = 1'b1;
        idle(2); rst = 1'b0;
        @(negedge clk);
        chk("R1", "init_n after mid reset", int'(init_n), 1);
        chk("R1", "regs after mid reset", int'({rd_rstctl, rd_fast}), 0);
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule